// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-beat data-memory requests from an 8-bit processor core into access cycles on an external asynchronous SRAM bus. The low address byte and the data byte take turns on one shared 8-bit bus. The high address byte has its own output. A pulse on the address-latch-enable output lets an external transparent latch keep the low byte once the bus moves on to data. Separate active-low read and write strobes time the memory access. All timing is counted in cycles of the internal clock, and no clock goes to the memory.

The external space is split at a programmable high-byte boundary into a lower and an upper sector. Each sector has its own two-bit wait setting, so a fast device and a slow device can share the bus. The shared bus is modelled as split pad signals: a driven value, a strong output enable, and a weak keeper enable. While the keeper is enabled and the controller is not driving, the pad holds the last value seen on the bus.

A requester raises `req_valid` with the address, direction and write data, and holds them until `req_ready` pulses. For a read, `rd_data` is valid in that same cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is asserted, `ale` and `ad_oe` are low, `rd_n` and `wr_n` are high, and `req_ready` is low.
- R2: An access starts the cycle after an idle cycle that sees `req_valid`. There is one cycle with `ale` high, then one cycle with `ale` low. Through both cycles the low address byte is driven on `ad_o` with `ad_oe` high, and both strobes are high. `a_hi` carries the high address byte for the whole access.
- R3: The active strobe is low for 1 + E consecutive cycles, where E is the extra count for the sector's wait code. Code 0 gives E=0, code 1 gives E=1, and codes 2 and 3 give E=2.
- R4: With wait code 3, one extra idle cycle (no drive, strobes high, no `ale`) follows the end cycle, so the next `ale` pulse comes one cycle later than with code 2.
- R5: An access whose high address byte is below `cfg_bound` uses `cfg_ws_lo`. An access whose high byte is equal to or above `cfg_bound` uses `cfg_ws_hi`.
- R6: During a write, `rd_n` stays high and the write data is driven on `ad_o` with `ad_oe` high for every cycle in which `wr_n` is low. The data stays driven for one more cycle after `wr_n` rises.
- R7: During a read, `ad_oe` is low while `rd_n` is low. The bus value on the last low cycle of `rd_n` is returned on `rd_data` in the next cycle. In that cycle `req_ready` is high for exactly one cycle. `req_ready` also pulses in the cycle after a write strobe.
- R8: When `keep_en` is high and the controller is not driving, `ad_keep` is high and `ad_o` shows the last bus value: the last driven byte, or the last byte read. When `keep_en` is low, `ad_keep` is low.
- R9: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_addr | input | AW (16) | Byte address of the access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (8) | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | DW (8) | Read data, valid with `req_ready` on a read |
| cfg_ws_lo | input | 2 | Wait code for the lower sector |
| cfg_ws_hi | input | 2 | Wait code for the upper sector |
| cfg_bound | input | AW-DW (8) | First high-byte value of the upper sector |
| keep_en | input | 1 | Bus-keeper enable |
| ad_o | output | DW (8) | Shared bus output value (driven or held) |
| ad_oe | output | 1 | Strong drive enable for the shared bus |
| ad_keep | output | 1 | Weak keeper enable for the shared bus |
| ad_i | input | DW (8) | Shared bus value seen at the pads |
| a_hi | output | AW-DW (8) | Dedicated high address byte |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Two things can land in the same cycle. One is the end of an access: the `req_ready` pulse, the write data hold or the read capture into the keeper. The other is a new request from the requester, which is accepted in the idle cycle straight after. The bench drives back-to-back requests that raise `req_valid` again at once after each completion, across all four wait codes and across both sides of the sector boundary. A per-clock reference model builds the expected pin sequence for each accepted request and compares every output, including the keeper value. Any slip between the end of one access and the acceptance of the next shows up as a misplaced `ale` pulse or a stale held value.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    cfg_ws_lo,
  input  logic [1:0]    cfg_ws_hi,
  input  logic [AW-DW-1:0] cfg_bound,
  input  logic          keep_en,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic          ad_keep,
  input  logic [DW-1:0] ad_i,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB, S_END, S_GAP} st_t;

  st_t          st;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wd_q;
  logic [1:0]    cnt, last_q;
  logic          gap_q;
  logic [DW-1:0] rd_q, kept_q;
  logic [DW-1:0] drv;

  logic       upper;
  logic [1:0] ws_sel;
  logic [1:0] ext;
  logic       strb_last;

  assign upper     = req_addr[AW-1:DW] >= cfg_bound;
  assign ws_sel    = upper ? cfg_ws_hi : cfg_ws_lo;
  assign ext       = (ws_sel == 2'd0) ? 2'd0 : (ws_sel == 2'd1) ? 2'd1 : 2'd2;
  assign strb_last = (st == S_STRB) && (cnt == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      cnt    <= '0;
      last_q <= '0;
      gap_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          we_q   <= req_we;
          wd_q   <= req_wdata;
          last_q <= ext;
          gap_q  <= (ws_sel == 2'd3);
          st     <= S_ADDR;
        end
        S_ADDR: st <= S_HOLD;
        S_HOLD: begin
          cnt <= '0;
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == last_q) begin
            if (!we_q) rd_q <= ad_i;
            st <= S_END;
          end else begin
            cnt <= cnt + 2'd1;
          end
        end
        S_END:   st <= gap_q ? S_GAP : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 kept_q <= '0;
    else if (ad_oe)             kept_q <= drv;
    else if (strb_last && !we_q) kept_q <= ad_i;
  end

  assign drv       = (st == S_ADDR || st == S_HOLD) ? addr_q[DW-1:0] : wd_q;
  assign ad_oe     = (st == S_ADDR) || (st == S_HOLD) ||
                     (we_q && (st == S_STRB || st == S_END));
  assign ad_o      = ad_oe ? drv : kept_q;
  assign ad_keep   = keep_en && !ad_oe;
  assign a_hi      = addr_q[AW-1:AW-HW];
  assign ale       = (st == S_ADDR);
  assign rd_n      = !((st == S_STRB) && !we_q);
  assign wr_n      = !((st == S_STRB) && we_q);
  assign req_ready = (st == S_END);
  assign rd_data   = rd_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic req_ready
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_ale_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_ale_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && rd_n && wr_n));
  assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  assert_ready_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> $past(!rd_n || !wr_n));
  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk u_xbus_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .req_ready(req_ready)
);

// File: tb/test_xbus_ctrl.sv
module test_xbus_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic req_we = 1'b0;
  logic [7:0] req_wdata = '0;
  logic req_ready;
  logic [7:0] rd_data;
  logic [1:0] cfg_ws_lo = '0, cfg_ws_hi = '0;
  logic [7:0] cfg_bound = 8'h80;
  logic keep_en = 1'b1;
  logic [7:0] ad_o;
  logic ad_oe, ad_keep;
  logic [7:0] ad_i = 8'hEE;
  logic [7:0] a_hi;
  logic ale, rd_n, wr_n;

  int total = 0, bad = 0, cyc = 0;
  bit run = 0, done = 0;

  always #2 clk = ~clk;

  xbus_ctrl i_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .cfg_ws_lo(cfg_ws_lo), .cfg_ws_hi(cfg_ws_hi),
    .cfg_bound(cfg_bound), .keep_en(keep_en), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_keep(ad_keep), .ad_i(ad_i), .a_hi(a_hi), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n)
  );

  // external latch and SRAM
  logic [7:0] lat_lo = '0;
  byte unsigned mem [int];

  function automatic logic [7:0] mem_val(logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(negedge ale) lat_lo = ad_o;
  always @(negedge rd_n) ad_i = mem_val({a_hi, lat_lo});
  always @(posedge rd_n) ad_i = 8'hEE;
  always @(posedge wr_n) if (rst_n) mem[int'({a_hi, lat_lo})] = ad_o;

  // reference model
  typedef struct packed {
    logic ale, rdn, wrn, oe, keep, rdy, we;
    logic [7:0] ad, ahi, rdat;
    logic [2:0] ph;
  } exp_t;

  exp_t q[$];
  logic [7:0] mkept = '0;

  function automatic exp_t idle_e();
    exp_t e = '0;
    e.rdn = 1; e.wrn = 1; e.keep = keep_en; e.ad = mkept; e.ph = 3'd0;
    return e;
  endfunction

  task automatic build(logic [15:0] a, logic we, logic [7:0] wd);
    exp_t e;
    logic [1:0] ws;
    logic [7:0] rv;
    int n;
    ws = (a[15:8] >= cfg_bound) ? cfg_ws_hi : cfg_ws_lo;  // R5
    n  = (ws == 2'd0) ? 1 : (ws == 2'd1) ? 2 : 3;          // R3
    rv = mem_val(a);
    e = '0; e.rdn = 1; e.wrn = 1; e.oe = 1; e.ad = a[7:0]; e.ahi = a[15:8]; e.we = we;
    e.ale = 1; e.ph = 3'd1; q.push_back(e);
    e.ale = 0; e.ph = 3'd2; q.push_back(e);
    for (int i = 0; i < n; i++) begin
      e.rdn = we; e.wrn = !we; e.oe = we; e.keep = !we && keep_en;
      e.ad = we ? wd : a[7:0]; e.ph = 3'd3; q.push_back(e);
    end
    e.rdn = 1; e.wrn = 1; e.rdy = 1; e.rdat = rv; e.ad = we ? wd : rv; e.ph = 3'd4;
    q.push_back(e);
    mkept = we ? wd : rv;
    if (ws == 2'd3) begin                                   // R4
      e = '0; e.rdn = 1; e.wrn = 1; e.keep = keep_en; e.ad = mkept; e.ph = 3'd5;
      q.push_back(e);
    end
  endtask

  bit cyc_bad;
  task automatic fail(string tag, string what, int act, int exp);
    $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    cyc_bad = 1;
  endtask

  always @(negedge clk) if (run && rst_n) begin
    exp_t e;
    bit act;
    string st;
    if (q.size() != 0) begin e = q.pop_front(); act = 1; end
    else begin e = idle_e(); act = 0; end
    cyc_bad = 0;
    st = (e.ph == 3'd3) ? "R3 R5" : (e.ph == 3'd5) ? "R4" : "R2";
    if (ale !== e.ale) fail(st, "ale", ale, e.ale);
    if (rd_n !== e.rdn) fail(st, "rd_n", rd_n, e.rdn);
    if (wr_n !== e.wrn) fail(st, "wr_n", wr_n, e.wrn);
    st = ((e.ph == 3'd3 || e.ph == 3'd4) && e.we) ? "R6" :
         (e.ph == 3'd4 || e.ph == 3'd3) ? "R7" : e.oe ? "R2" : "R8";
    if (ad_oe !== e.oe) fail(st, "ad_oe", ad_oe, e.oe);
    if ((e.oe || e.keep) && ad_o !== e.ad) fail(st, "ad_o", ad_o, e.ad);
    if (ad_keep !== e.keep) fail("R8", "ad_keep", ad_keep, e.keep);
    if (req_ready !== e.rdy) fail("R7", "req_ready", req_ready, e.rdy);
    if (e.rdy && !e.we && rd_data !== e.rdat) fail("R7", "rd_data", rd_data, e.rdat);
    if (e.ph != 3'd0 && e.ph != 3'd5 && a_hi !== e.ahi) fail("R2", "a_hi", a_hi, e.ahi);
    if ((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n)))
      fail("R9", "strobe overlap", {ale, rd_n, wr_n}, 3'b011);
    total++;
    if (cyc_bad) bad++;
    if (!act && req_valid) build(req_addr, req_we, req_wdata);
  end

  task automatic acc(logic [15:0] a, logic we, logic [7:0] wd);
    req_addr = a; req_we = we; req_wdata = wd; req_valid = 1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    total++;  // R1 reset state
    if (ale !== 0 || rd_n !== 1 || wr_n !== 1 || ad_oe !== 0 || req_ready !== 0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual=%b expected=01100",
               {ale, rd_n, wr_n, ad_oe, req_ready});
    end
    @(posedge clk); #1;
    rst_n = 1; run = 1;
    idle(2);

    // R5 R6 R7 basic writes and reads in both sectors
    cfg_bound = 8'h80; cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd2;
    acc(16'h1234, 1, 8'hA5);
    acc(16'h1234, 0, 8'h00);
    acc(16'h9000, 1, 8'h3C);
    acc(16'h9000, 0, 8'h00);
    acc(16'h9001, 0, 8'h00);
    idle(3);

    // R3 R4 each wait code, back-to-back
    for (int w = 0; w < 4; w++) begin
      cfg_ws_lo = w[1:0];
      acc(16'h2000 + 16'(w), 1, 8'h50 + 8'(w));
      acc(16'h2000 + 16'(w), 0, 8'h00);
      acc(16'h2100 + 16'(w), 0, 8'h00);
      idle(2);
    end

    // R5 boundary
    cfg_bound = 8'h40; cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd3;
    acc(16'h3FFF, 0, 8'h00);
    acc(16'h4000, 0, 8'h00);
    acc(16'h4000, 1, 8'hC3);
    acc(16'h3FFF, 1, 8'h7E);
    acc(16'h4000, 0, 8'h00);
    acc(16'h3FFF, 0, 8'h00);
    idle(2);

    // R8 keeper disabled then re-enabled
    keep_en = 0;
    acc(16'h0510, 1, 8'h99);
    acc(16'h0510, 0, 8'h00);
    idle(3);
    keep_en = 1;
    idle(3);
    acc(16'h0777, 0, 8'h00);
    idle(3);

    // R5 all upper, top of range
    cfg_bound = 8'h00; cfg_ws_hi = 2'd1; cfg_ws_lo = 2'd3;
    acc(16'h0001, 1, 8'h11);
    acc(16'hFFFF, 1, 8'hEF);
    acc(16'hFFFF, 0, 8'h00);
    acc(16'h0001, 0, 8'h00);
    idle(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule